// File: doc/BRIEF.md
# Dependence Chain Replay Buffer

This block stores a short chain of already-decoded micro-ops and feeds it repeatedly to the rename stage while the core is stalled on a long-latency load. The chain is captured from the back-end at up to four micro-ops per cycle. Micro-ops flagged as control flow are dropped on the way in, and the survivors are packed densely in program order. The number of stored entries is held in a length register that is loaded when the last fill beat arrives.

A start pulse puts a loaded chain into replay. Each cycle the block then offers a group of up to four micro-ops to rename. When the chain length is not a multiple of four, a group that runs past the last entry continues from entry 0 in the same cycle. When rename withholds ready, the block holds its position. An exit event, raised when the blocking load's data returns, ends replay. The chain stays stored and can be replayed again. The micro-op payload is an opaque 64-bit word.

Top module: `chain_replay_buf`

## Requirements
- R1: The chain holds at most 32 entries. Kept micro-ops beyond entry 31 are discarded, and `chain_len` saturates at 32.
- R2: A fill beat carries `fill_cnt` (0..4) micro-ops in lanes 0..`fill_cnt`-1. Lane k occupies `fill_data[64k +: 64]`. Lanes with `fill_ctl[k]`=1 are dropped, and the kept lanes are appended in lane order after the entries already written in this fill.
- R3: A fill that ends (`fill_last`=1) with zero kept entries leaves the block idle. `chain_len` keeps its previous value, and a following start produces no issue.
- R4: A start pulse has effect only when a complete chain is loaded and no fill beat arrives in the same cycle. A start pulse during a fill is ignored.
- R5: While replaying, lanes 0..g-1 are valid and all other lanes are invalid with zero data, where g = min(4, `chain_len`). Outside replay, no lane is valid.
- R6: Replay begins at entry 0, and after the last entry issues, issue resumes at entry 0.
- R7: Lane k presents entry (p+k) mod `chain_len`, where p is the current read position. A group wraps to entry 0 mid-cycle and stays in order.
- R8: A group is consumed only when `iss_rdy` is high. While `iss_rdy` is low, the valids and data stay stable.
- R9: An exit event during replay takes priority over consumption. From the next cycle no lane is valid, and the chain remains loaded, so a new start replays it from entry 0.
- R10: After reset, no lane is valid and `chain_len` is 0.
- R11: Fill beats that arrive during replay are ignored. The stored chain and its length are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_vld | input | 1 | Fill beat present |
| fill_cnt | input | 3 | Number of lanes in the beat (0..4) |
| fill_ctl | input | 4 | Per-lane control-flow flag (lane dropped) |
| fill_data | input | 256 | Four 64-bit micro-op lanes |
| fill_last | input | 1 | Final beat of the chain |
| start | input | 1 | Begin replay of the loaded chain |
| exit_evt | input | 1 | Blocking load data returned; leave replay |
| iss_rdy | input | 1 | Rename accepts the offered group |
| iss_vld | output | 4 | Per-lane valid of the issue group |
| iss_data | output | 256 | Four 64-bit issued micro-ops |
| chain_len | output | 6 | Stored chain length |
| replaying | output | 1 | Replay mode active |

## Verification
The assertions assume that `fill_cnt` never exceeds four. They also assume that rename treats a group shown in an exit cycle as not taken, which is why the checks look only at the cycle after an exit. The random stimulus draws `fill_cnt` from 0..4 only. It mixes start, exit, backpressure and fill beats freely, including fills and starts in illegal states. The assertions cover only the outputs that the protocol defines for those cases.

// File: rtl/crb_pkg.sv
package crb_pkg;
  parameter int unsigned CRB_DEPTH = 32;
  parameter int unsigned CRB_LANES = 4;
  parameter int unsigned CRB_UOP_W = 64;

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_LOADED, ST_REPLAY} crb_state_e;

  // Position reached by stepping from base by step inside a ring of len entries.
  // Valid when base < len and step <= len.
  function automatic int unsigned ring_step(int unsigned base, int unsigned step,
                                            int unsigned len);
    return (base + step >= len) ? base + step - len : base + step;
  endfunction

  // Lanes offered per cycle for a chain of len entries.
  function automatic int unsigned group_width(int unsigned len, int unsigned lanes);
    return (len < lanes) ? len : lanes;
  endfunction
endpackage

// File: rtl/crb_fill_pack.sv
module crb_fill_pack
  import crb_pkg::*;
#(
  parameter int unsigned DEPTH = CRB_DEPTH,
  parameter int unsigned LANES = CRB_LANES,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned LW = $clog2(DEPTH + 1),
  localparam int unsigned CW = $clog2(LANES + 1)
) (
  input  logic [LW-1:0]            wr_base,
  input  logic [CW-1:0]            fill_cnt,
  input  logic [LANES-1:0]         fill_ctl,
  output logic [LANES-1:0]         wen,
  output logic [LANES-1:0][PW-1:0] waddr,
  output logic [LW-1:0]            wr_next
);
  int unsigned pos;

  always_comb begin
    pos = int'(wr_base);
    for (int k = 0; k < int'(LANES); k++) begin
      wen[k]   = 1'b0;
      waddr[k] = '0;
      if (k < int'(fill_cnt) && !fill_ctl[k] && pos < DEPTH) begin
        wen[k]   = 1'b1;
        waddr[k] = PW'(pos);
        pos      = pos + 1;
      end
    end
    wr_next = LW'(pos);
  end
endmodule

// File: rtl/crb_store.sv
module crb_store
  import crb_pkg::*;
#(
  parameter int unsigned DEPTH = CRB_DEPTH,
  parameter int unsigned LANES = CRB_LANES,
  parameter int unsigned UOP_W = CRB_UOP_W,
  localparam int unsigned PW = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic [LANES-1:0]            wen,
  input  logic [LANES-1:0][PW-1:0]    waddr,
  input  logic [LANES*UOP_W-1:0]      wdata,
  input  logic [LANES-1:0][PW-1:0]    raddr,
  output logic [LANES-1:0][UOP_W-1:0] rdata
);
  logic [UOP_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int k = 0; k < int'(LANES); k++) begin
      if (wen[k]) mem[waddr[k]] <= wdata[k*UOP_W +: UOP_W];
    end
  end

  for (genvar g = 0; g < int'(LANES); g++) begin : g_rd
    assign rdata[g] = mem[raddr[g]];
  end
endmodule

// File: rtl/crb_issue_seq.sv
module crb_issue_seq
  import crb_pkg::*;
#(
  parameter int unsigned DEPTH = CRB_DEPTH,
  parameter int unsigned LANES = CRB_LANES,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned LW = $clog2(DEPTH + 1),
  localparam int unsigned CW = $clog2(LANES + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     restart,
  input  logic                     advance,
  input  logic [LW-1:0]            len,
  output logic [PW-1:0]            rd_ptr,
  output logic [CW-1:0]            grp,
  output logic [LANES-1:0][PW-1:0] lane_addr
);
  assign grp = CW'(group_width(int'(len), LANES));

  for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
    assign lane_addr[g] = PW'(ring_step(int'(rd_ptr), g, int'(len)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rd_ptr <= '0;
    else if (restart) rd_ptr <= '0;
    else if (advance) rd_ptr <= PW'(ring_step(int'(rd_ptr), int'(grp), int'(len)));
  end
endmodule

// File: rtl/chain_replay_buf.sv
module chain_replay_buf
  import crb_pkg::*;
#(
  parameter int unsigned DEPTH = CRB_DEPTH,
  parameter int unsigned LANES = CRB_LANES,
  parameter int unsigned UOP_W = CRB_UOP_W,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned LW = $clog2(DEPTH + 1),
  localparam int unsigned CW = $clog2(LANES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fill_vld,
  input  logic [CW-1:0]          fill_cnt,
  input  logic [LANES-1:0]       fill_ctl,
  input  logic [LANES*UOP_W-1:0] fill_data,
  input  logic                   fill_last,
  input  logic                   start,
  input  logic                   exit_evt,
  input  logic                   iss_rdy,
  output logic [LANES-1:0]       iss_vld,
  output logic [LANES*UOP_W-1:0] iss_data,
  output logic [LW-1:0]          chain_len,
  output logic                   replaying
);
  crb_state_e state;
  logic [LW-1:0] wr_ptr;

  // Named internal events
  logic replay_on, fill_take, start_take, advance;
  logic [LW-1:0] wr_base, wr_next;
  logic [LANES-1:0] wen;
  logic [LANES-1:0][PW-1:0] waddr, lane_addr;
  logic [LANES-1:0][UOP_W-1:0] rdata;
  logic [PW-1:0] rd_ptr;
  logic [CW-1:0] grp;

  assign replay_on  = (state == ST_REPLAY);
  assign fill_take  = fill_vld && !replay_on;
  assign start_take = start && (state == ST_LOADED) && !fill_take;
  assign advance    = replay_on && iss_rdy && !exit_evt;
  assign wr_base    = (state == ST_FILL) ? wr_ptr : '0;
  assign replaying  = replay_on;

  crb_fill_pack #(.DEPTH(DEPTH), .LANES(LANES)) u_pack (
    .wr_base(wr_base), .fill_cnt(fill_cnt), .fill_ctl(fill_ctl),
    .wen(wen), .waddr(waddr), .wr_next(wr_next)
  );

  crb_store #(.DEPTH(DEPTH), .LANES(LANES), .UOP_W(UOP_W)) u_store (
    .clk(clk), .wen(wen & {LANES{fill_take}}), .waddr(waddr), .wdata(fill_data),
    .raddr(lane_addr), .rdata(rdata)
  );

  crb_issue_seq #(.DEPTH(DEPTH), .LANES(LANES)) u_seq (
    .clk(clk), .rst_n(rst_n), .restart(start_take), .advance(advance),
    .len(chain_len), .rd_ptr(rd_ptr), .grp(grp), .lane_addr(lane_addr)
  );

  for (genvar g = 0; g < int'(LANES); g++) begin : g_out
    assign iss_vld[g] = replay_on && (g < int'(grp));
    assign iss_data[g*UOP_W +: UOP_W] = iss_vld[g] ? rdata[g] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      wr_ptr    <= '0;
      chain_len <= '0;
    end else if (fill_take) begin
      if (fill_last) begin
        if (wr_next == '0) state <= ST_IDLE;
        else begin
          state     <= ST_LOADED;
          chain_len <= wr_next;
        end
      end else begin
        state  <= ST_FILL;
        wr_ptr <= wr_next;
      end
    end else if (start_take) begin
      state <= ST_REPLAY;
    end else if (replay_on && exit_evt) begin
      state <= ST_LOADED;
    end
  end
endmodule

// File: rtl/crb_chk.sv
module crb_chk #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LANES = 4,
  parameter int unsigned UOP_W = 64,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   iss_rdy,
  input logic                   exit_evt,
  input logic [LANES-1:0]       iss_vld,
  input logic [LANES*UOP_W-1:0] iss_data,
  input logic [LW-1:0]          chain_len,
  input logic                   replay_on,
  input logic [PW-1:0]          rd_ptr
);
  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    int'(chain_len) <= int'(DEPTH)); // R1
  AST_REPLAY_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    replay_on |-> chain_len != '0); // R3
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !replay_on |-> iss_vld == '0); // R5
  AST_VALID_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld & (iss_vld + 1'b1)) == '0); // R5
  AST_PTR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    replay_on |-> int'(rd_ptr) < int'(chain_len)); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (replay_on && !iss_rdy && !exit_evt) |=> ($stable(iss_vld) && $stable(iss_data))); // R8
  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (replay_on && exit_evt) |=> iss_vld == '0); // R9
endmodule

bind chain_replay_buf crb_chk #(.DEPTH(DEPTH), .LANES(LANES), .UOP_W(UOP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_rdy(iss_rdy), .exit_evt(exit_evt),
  .iss_vld(iss_vld), .iss_data(iss_data), .chain_len(chain_len),
  .replay_on(replay_on), .rd_ptr(rd_ptr)
);

// File: tb/tb_chain_replay_buf.sv
`timescale 1ns/1ps
module tb_chain_replay_buf;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fill_vld = 1'b0;
  logic [2:0] fill_cnt = '0;
  logic [3:0] fill_ctl = '0;
  logic [255:0] fill_data = '0;
  logic fill_last = 1'b0, start = 1'b0, exit_evt = 1'b0, iss_rdy = 1'b0;
  logic [3:0] iss_vld;
  logic [255:0] iss_data;
  logic [5:0] chain_len;
  logic replaying;

  always #2.5 clk = ~clk;

  chain_replay_buf dut (
    .clk(clk), .rst_n(rst_n), .fill_vld(fill_vld), .fill_cnt(fill_cnt),
    .fill_ctl(fill_ctl), .fill_data(fill_data), .fill_last(fill_last),
    .start(start), .exit_evt(exit_evt), .iss_rdy(iss_rdy),
    .iss_vld(iss_vld), .iss_data(iss_data), .chain_len(chain_len),
    .replaying(replaying)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;

  // Reference model: 0 idle, 1 filling, 2 loaded, 3 replaying
  logic [63:0] mm [32];
  int mstate = 0, mwr = 0, mlen = 0, mrd = 0;

  function automatic logic [63:0] uop(int id);
    return 64'hC0DE_0000_0000_0000 | 64'(id);
  endfunction

  function automatic int gsz();
    return (mlen < 4) ? mlen : 4;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    int base;
    if (mstate != 3 && fill_vld) begin
      base = (mstate == 1) ? mwr : 0;
      for (int k = 0; k < int'(fill_cnt); k++) begin
        if (!fill_ctl[k] && base < 32) begin
          mm[base] = fill_data[k*64 +: 64];
          base++;
        end
      end
      if (fill_last) begin
        if (base == 0) mstate = 0;
        else begin mstate = 2; mlen = base; end
      end else begin
        mstate = 1; mwr = base;
      end
    end else if (mstate == 2 && start) begin
      mstate = 3; mrd = 0;
    end else if (mstate == 3) begin
      if (exit_evt) mstate = 2;
      else if (iss_rdy) mrd = (mrd + gsz()) % mlen;
    end
  endtask

  task automatic compare_all();
    logic ev;
    logic [63:0] ed;
    chk("R1 chain_len", 64'(chain_len), 64'(mlen));
    for (int k = 0; k < 4; k++) begin
      ev = (mstate == 3) && (k < gsz());
      chk("R5 lane valid", 64'(iss_vld[k]), 64'(ev));
      ed = ev ? mm[(mrd + k) % mlen] : 64'h0;
      chk("R7 lane data", iss_data[k*64 +: 64], ed);
    end
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic quiet();
    fill_vld = 0; fill_cnt = 0; fill_ctl = 0; fill_last = 0;
    start = 0; exit_evt = 0;
  endtask

  task automatic fill_beat(int cnt, logic [3:0] ctl, bit last, int id0);
    quiet();
    fill_vld = 1; fill_cnt = 3'(cnt); fill_ctl = ctl; fill_last = last;
    for (int k = 0; k < 4; k++) fill_data[k*64 +: 64] = uop(id0 + k);
    cycle();
    quiet();
  endtask

  task automatic pulse_start();
    quiet(); start = 1; cycle(); quiet();
  endtask

  task automatic pulse_exit();
    quiet(); exit_evt = 1; cycle(); quiet();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 valid after reset", 64'(iss_vld), 64'h0);
    chk("R10 len after reset", 64'(chain_len), 64'h0);
    iss_rdy = 1;

    // chain: ids 0,2,3,10,11,12 (lane 1 of first beat is control flow)
    fill_beat(4, 4'b0010, 0, 0);
    quiet(); start = 1; cycle(); quiet();
    chk("R4 start during fill ignored", 64'(iss_vld), 64'h0);
    fill_beat(3, 4'b0000, 1, 10);
    chk("R2 packed length", 64'(chain_len), 64'd6);
    pulse_start();
    chk("R6 replay begins at entry 0", iss_data[63:0], uop(0));
    chk("R2 control lane dropped", iss_data[127:64], uop(2));
    cycle();
    chk("R7 mid-group wrap", iss_data[191:128], uop(0));
    chk("R7 order after wrap", iss_data[255:192], uop(2));
    cycle();
    chk("R6 loop continues", iss_data[63:0], uop(3));
    iss_rdy = 0;
    cycle(); cycle();
    chk("R8 held under backpressure", iss_data[63:0], uop(3));
    iss_rdy = 1;
    fill_beat(4, 4'b0000, 1, 40);
    chk("R11 fill ignored in replay", 64'(chain_len), 64'd6);
    pulse_exit();
    chk("R9 exit clears valids", 64'(iss_vld), 64'h0);
    pulse_start();
    chk("R9 restart from entry 0", iss_data[63:0], uop(0));
    chk("R11 chain intact", iss_data[255:192], uop(10));
    pulse_exit();

    // zero-length fill
    fill_beat(2, 4'b0011, 1, 20);
    pulse_start();
    chk("R3 zero fill stays idle", 64'(iss_vld), 64'h0);
    chk("R3 length kept", 64'(chain_len), 64'd6);

    // overflow
    for (int b = 0; b < 10; b++) fill_beat(4, 4'b0000, b == 9, 100 + 4*b);
    chk("R1 length saturates", 64'(chain_len), 64'd32);
    pulse_start();
    repeat (20) cycle();
    pulse_exit();

    // short chain
    fill_beat(3, 4'b0000, 1, 60);
    pulse_start();
    chk("R5 short chain group", 64'(iss_vld), 64'h7);
    repeat (5) cycle();
    pulse_exit();

    // random mix
    for (int i = 0; i < 4000; i++) begin
      quiet();
      fill_vld  = ($urandom_range(0, 5) == 0);
      fill_cnt  = 3'($urandom_range(0, 4));
      fill_ctl  = 4'($urandom_range(0, 15) & $urandom_range(0, 15));
      fill_last = ($urandom_range(0, 2) == 0);
      for (int k = 0; k < 4; k++) fill_data[k*64 +: 64] = {$urandom, $urandom};
      start     = ($urandom_range(0, 3) == 0);
      exit_evt  = ($urandom_range(0, 19) == 0);
      iss_rdy   = ($urandom_range(0, 9) < 7);
      cycle();
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule